// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Combiner

This block keeps the interrupt status of two storage channels and merges it into one active-high interrupt line. Each channel's pending flag can be seen in two places: a per-channel legacy status byte and a shared summary byte. Both views always show the same value. Software can acknowledge a channel through either view, and the acknowledgement clears the flag in both.

Each channel drives a level input. A rising edge on that input raises the channel's flag and a falling edge drops it. Between edges, software may acknowledge the flag by writing a one to it. The summary byte also holds one block bit per channel. A set block bit keeps that channel's flag off the interrupt line, but the flag itself stays visible. The interrupt line is registered.

Register writes arrive as a dword index plus a 32-bit data word with one enable per byte lane. Byte lane i of the access targets byte offset `4*wr_word_i + i`. Reads take a byte offset and return the byte with no clock delay.

Top module: `intr_status_combiner`

## Requirements
- R1: After reset, both flags and both block bits are zero. Every readable byte returns 0x00 and `irq_o` is low.
- R2: A rising edge on `chan_level_i[c]` sets channel c's flag one clock later, and the flag shows in both views. Channel 0 appears at offset 0x50 bit 2 and at offset 0x71 bit 2. Channel 1 appears at offset 0x57 bit 4 and at offset 0x71 bit 3.
- R3: A falling edge on `chan_level_i[c]` clears channel c's flag in both views one clock later.
- R4: Writing a one to a channel's flag bit in its legacy byte clears that flag in both views. Writing a zero to the bit has no effect.
- R5: Writing a one to a channel's flag bit in the summary byte (0x71 bit 2 or bit 3) clears that flag in both views.
- R6: No write ever sets a flag. The other bits of the legacy bytes always read zero and cannot be written.
- R7: The block bits sit at offset 0x71 bit 4 (channel 0) and bit 5 (channel 1). Any enabled write to byte 0x71 loads them, and they read back as written.
- R8: `irq_o` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), taken one clock after the flag or block bit changes.
- R9: When a rising edge and a clearing write for the same channel arrive in the same cycle, the flag ends up set.
- R10: A byte lane whose enable is low has no effect, even when its data would clear a flag.
- R11: Any offset other than 0x50, 0x57 and 0x71 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_level_i | input | 2 | Interrupt level from each channel |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_word_i | input | 6 | Dword index of the write (byte offset divided by 4) |
| wr_be_i | input | 4 | Byte-lane enables |
| wr_data_i | input | 32 | Write data; lane i is bits 8i+7..8i |
| rd_addr_i | input | 8 | Byte offset to read |
| rd_data_o | output | 8 | Read data for `rd_addr_i` |
| irq_o | output | 1 | Combined interrupt, active high, registered |

## Verification
Each channel keeps a single flag bit, which both views show. A wrong flag therefore shows as a mismatch in the read bytes one clock after the edge or write that caused it. It shows on `irq_o` one clock after that, unless the channel is blocked. A wrong block bit shows only when it is read back, or as a wrong `irq_o` while its channel's flag is pending. For that reason the bench reads the block bits back while the flag is held set. The single-cycle collision between a rising edge and a clear is driven on purpose, because it leaves no trace a cycle later except the final flag value.

// File: rtl/intr_comb_pkg.sv
package intr_comb_pkg;
  localparam int NCH = 2;

  localparam logic [7:0] LEG0_OFS = 8'h50;
  localparam logic [7:0] LEG1_OFS = 8'h57;
  localparam logic [7:0] SUM_OFS  = 8'h71;

  localparam int LEG0_BIT = 2;
  localparam int LEG1_BIT = 4;
  localparam int SUMF_LSB = 2;  // flags at bits 3:2 of the summary byte
  localparam int SUMB_LSB = 4;  // blocks at bits 5:4 of the summary byte

  // Combined interrupt level from flags and block bits.
  function automatic logic irq_calc(input logic [NCH-1:0] f, input logic [NCH-1:0] b);
    return |(f & ~b);
  endfunction

  // Byte seen at a given offset.
  function automatic logic [7:0] reg_view(input logic [7:0] ofs,
                                          input logic [NCH-1:0] f,
                                          input logic [NCH-1:0] b);
    logic [7:0] v;
    v = '0;
    case (ofs)
      LEG0_OFS: v[LEG0_BIT] = f[0];
      LEG1_OFS: v[LEG1_BIT] = f[1];
      SUM_OFS: begin
        v[SUMF_LSB +: NCH] = f;
        v[SUMB_LSB +: NCH] = b;
      end
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/icomb_wr_decode.sv
module icomb_wr_decode
  import intr_comb_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WORD_W = ADDR_W - LANE_W
) (
  input  logic                 wr_en_i,
  input  logic [WORD_W-1:0]    wr_word_i,
  input  logic [LANES-1:0]     wr_be_i,
  input  logic [8*LANES-1:0]   wr_data_i,
  output logic [NCH-1:0]       clr_req_o,
  output logic                 blk_we_o,
  output logic [NCH-1:0]       blk_wdata_o
);
  always_comb begin
    clr_req_o   = '0;
    blk_we_o    = 1'b0;
    blk_wdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [ADDR_W-1:0] ofs;
      logic [7:0]        byte_v;
      ofs    = {wr_word_i, LANE_W'(l)};
      byte_v = wr_data_i[8*l +: 8];
      if (wr_en_i && wr_be_i[l]) begin
        if (ofs == LEG0_OFS && byte_v[LEG0_BIT]) clr_req_o[0] = 1'b1;
        if (ofs == LEG1_OFS && byte_v[LEG1_BIT]) clr_req_o[1] = 1'b1;
        if (ofs == SUM_OFS) begin
          for (int c = 0; c < NCH; c++)
            if (byte_v[SUMF_LSB + c]) clr_req_o[c] = 1'b1;
          blk_we_o    = 1'b1;
          blk_wdata_o = byte_v[SUMB_LSB +: NCH];
        end
      end
    end
  end
endmodule

// File: rtl/icomb_chan_flag.sv
module icomb_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q;
  logic rise_evt, fall_evt;

  assign rise_evt = level_i & ~prev_q;
  assign fall_evt = ~level_i & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (rise_evt)                flag_q <= 1'b1;
      else if (fall_evt || clr_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> flag_q);
  // R3
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !flag_q);
  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise_evt) |=> !flag_q);
  // R9
  rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && rise_evt) |=> flag_q);
  // R6
  no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> !$rose(flag_q));
endmodule

// File: rtl/icomb_irq_out.sv
module icomb_irq_out
  import intr_comb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] flags_i,
  input  logic [NCH-1:0] blocks_i,
  output logic           irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_calc(flags_i, blocks_i);
  end

  assign irq_o = irq_q;

  // R8
  ch0_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[0] && !blocks_i[0]) |=> irq_o);
  // R8
  ch1_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[1] && !blocks_i[1]) |=> irq_o);
  // R8
  quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & ~blocks_i) == '0) |=> !irq_o);
endmodule

// File: rtl/intr_status_combiner.sv
module intr_status_combiner
  import intr_comb_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WORD_W = ADDR_W - LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       chan_level_i,
  input  logic                 wr_en_i,
  input  logic [WORD_W-1:0]    wr_word_i,
  input  logic [LANES-1:0]     wr_be_i,
  input  logic [8*LANES-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [7:0]           rd_data_o,
  output logic                 irq_o
);
  logic [NCH-1:0] clr_req;
  logic           blk_we;
  logic [NCH-1:0] blk_wdata;
  logic [NCH-1:0] blk_q;
  logic [NCH-1:0] flags;

  icomb_wr_decode #(.LANES(LANES), .ADDR_W(ADDR_W)) dec_i (
    .wr_en_i     (wr_en_i),
    .wr_word_i   (wr_word_i),
    .wr_be_i     (wr_be_i),
    .wr_data_i   (wr_data_i),
    .clr_req_o   (clr_req),
    .blk_we_o    (blk_we),
    .blk_wdata_o (blk_wdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    icomb_chan_flag flag_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (chan_level_i[c]),
      .clr_i   (clr_req[c]),
      .flag_o  (flags[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_we) blk_q <= blk_wdata;
  end

  icomb_irq_out irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_i  (flags),
    .blocks_i (blk_q),
    .irq_o    (irq_o)
  );

  assign rd_data_o = reg_view(rd_addr_i, flags, blk_q);

  // R7
  blk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_we |=> (blk_q == $past(blk_wdata)));
  // R7
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_we |=> $stable(blk_q));
endmodule

// File: tb/intr_status_combiner_tb.sv
module intr_status_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lvl = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_word = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  intr_status_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .chan_level_i(lvl), .wr_en_i(wr_en),
    .wr_word_i(wr_word), .wr_be_i(wr_be), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [7:0] byte_addr, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_word = byte_addr[7:2]; wr_be = be; wr_data = d;
    step();
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk_rd("R1 leg0", 8'h50, 8'h00);
    chk_rd("R1 leg1", 8'h57, 8'h00);
    chk_rd("R1 sum", 8'h71, 8'h00);
  endtask

  task automatic t_rise();
    lvl[0] = 1'b1; step();
    chk_rd("R2 leg0 set", 8'h50, 8'h04);
    chk_rd("R2 sum ch0", 8'h71, 8'h04);
    chk("R8 latency", {7'b0, irq}, 8'h00);
    step();
    chk("R8 irq ch0", {7'b0, irq}, 8'h01);
    lvl[1] = 1'b1; step();
    chk_rd("R2 leg1 set", 8'h57, 8'h10);
    chk_rd("R2 sum both", 8'h71, 8'h0C);
  endtask

  task automatic t_fall();
    lvl[0] = 1'b0; step();
    chk_rd("R3 leg0 clr", 8'h50, 8'h00);
    chk_rd("R3 sum ch1 only", 8'h71, 8'h08);
    step();
    chk("R8 irq ch1 holds", {7'b0, irq}, 8'h01);
    lvl[1] = 1'b0; step();
    chk_rd("R3 sum empty", 8'h71, 8'h00);
    step();
    chk("R8 irq drops", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_legacy_ack();
    lvl[0] = 1'b1; step(); step();
    wr(8'h50, 4'b0001, 32'h0000_00FB);
    chk_rd("R4 zero write keeps", 8'h50, 8'h04);
    chk_rd("R6 other bits stay 0", 8'h71, 8'h04);
    wr(8'h50, 4'b0001, 32'h0000_0004);
    chk_rd("R4 leg0 ack", 8'h50, 8'h00);
    chk_rd("R4 sum mirror", 8'h71, 8'h00);
    step();
    chk("R4 irq after ack", {7'b0, irq}, 8'h00);
    lvl[0] = 1'b0; step();
    chk_rd("R3 fall after ack", 8'h71, 8'h00);
  endtask

  task automatic t_summary_ack();
    lvl[1] = 1'b1; step();
    wr(8'h70, 4'b0010, 32'h0000_0800);
    chk_rd("R5 leg1 mirror", 8'h57, 8'h00);
    chk_rd("R5 sum ack", 8'h71, 8'h00);
    lvl[1] = 1'b0; step();
  endtask

  task automatic t_block();
    lvl[0] = 1'b1; step(); step();
    chk("R8 irq pre-block", {7'b0, irq}, 8'h01);
    wr(8'h70, 4'b0010, 32'h0000_1000);
    chk_rd("R7 block0 readback", 8'h71, 8'h14);
    step();
    chk("R8 blocked", {7'b0, irq}, 8'h00);
    wr(8'h70, 4'b0010, 32'h0000_2000);
    chk_rd("R7 block1 readback", 8'h71, 8'h24);
    step();
    chk("R8 unblocked ch0", {7'b0, irq}, 8'h01);
    wr(8'h70, 4'b0010, 32'h0000_0000);
  endtask

  task automatic t_lanes();
    wr(8'h50, 4'b1110, 32'hFFFF_FF04);
    chk_rd("R10 disabled lane", 8'h50, 8'h04);
    lvl[1] = 1'b1; step();
    wr(8'h54, 4'b1000, 32'h1000_0000);
    chk_rd("R10 lane3 hits 0x57", 8'h57, 8'h00);
    chk_rd("R10 ch0 untouched", 8'h71, 8'h04);
    lvl = 2'b00; step();
  endtask

  task automatic t_collide();
    lvl[0] = 1'b1;
    wr(8'h50, 4'b0001, 32'h0000_0004);
    chk_rd("R9 rise beats ack", 8'h50, 8'h04);
    lvl[0] = 1'b0; step();
  endtask

  task automatic t_no_set();
    wr(8'h50, 4'b0001, 32'h0000_00FF);
    wr(8'h54, 4'b1000, 32'hFF00_0000);
    wr(8'h70, 4'b0010, 32'h0000_CF00);
    chk_rd("R6 leg0 no set", 8'h50, 8'h00);
    chk_rd("R6 leg1 no set", 8'h57, 8'h00);
    chk_rd("R6 sum no set", 8'h71, 8'h00);
    step();
    chk("R6 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_unmapped();
    wr(8'h60, 4'b1111, 32'hFFFF_FFFF);
    chk_rd("R11 0x60", 8'h60, 8'h00);
    chk_rd("R11 0x51", 8'h51, 8'h00);
    chk_rd("R11 sum intact", 8'h71, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_legacy_ack();
    t_summary_ack();
    t_block();
    t_lanes();
    t_collide();
    t_no_set();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule